// File: doc/BRIEF.md
# Indirect Management Register Bridge

This block sits at the target end of a multi-drop management bus. The serial framing has already been removed. Each bus access arrives as one parallel request that carries a bus (PHY) address, a register number, a write flag and a 16-bit write value. Behind the bridge is a register array addressed by a 5-bit device and a 5-bit register number. The bridge reaches that array through a fixed-latency access port.

A 5-bit strap input selects how the array is reached. With the strap at zero the bridge works in direct mode. Every bus address names an internal device, and the register number passes through unchanged. With a non-zero strap the bridge works in indirect mode. Only requests at the strapped bus address reach the bridge's own registers: a command register at register 0 and a data register at register 1. The host loads the data register, writes an opcode word with target fields into the command register, then polls the busy bit in register 0 until it reads zero. After a read command, the data register holds the result.

Requests use a valid/ready handshake. Every accepted request yields exactly one response beat on a valid/ready response channel. `req_ready` stays low while a response is still waiting for `rsp_ready`, and also while a direct-mode access is in flight, which gives back-pressure from the response side to the request side. A response beat stays valid, with stable data, until it is accepted. Control pins (strap, register-array port) are plain signals.

Top module: `mgmt_indirect_bridge`

## Requirements
- R1: With strap 0, every accepted request causes one register-array access. The device is `req_phy`, the register is `req_reg`, and the write flag and value are taken from the request. The read response carries the array data; a write response carries 0.
- R2: With a non-zero strap, a request whose `req_phy` differs from the strap causes no array access and no state change. Its response carries 16'hFFFF for a read and 0 for a write.
- R3: In indirect mode, reading register 0 returns the busy flag in bit 15 and the low 15 bits of the last accepted command word in bits 14:0. Busy reads as 1 from the cycle after a valid command is accepted.
- R4: The command word layout is: bits 15:10 opcode, bits 9:5 target device, bits 4:0 target register. Opcode 6'b100110 (word 0x9800 | fields) is a read, and opcode 6'b100101 (word 0x9400 | fields) is a write.
- R5: A write command causes one array write to the decoded target. The write value is the data register's content at the moment the command was accepted.
- R6: After a read command finishes, reading register 1 returns the array value of the decoded target.
- R7: Busy stays set for exactly RF_LATENCY+1 cycles, which is well within 16 host polls. The array port's enable is a single-cycle pulse per operation.
- R8: While busy is set, writes to register 0 and to register 1 are ignored.
- R9: A command with any other opcode leaves busy clear and causes no array access.
- R10: `req_ready` is low whenever a response is pending or a direct access is in flight. A pending response holds its valid and data until `rsp_ready`.
- R11: In indirect mode, register numbers 2 to 31 read as 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_addr | input | 5 | Mode strap; 0 selects direct mode, otherwise the bridge's own bus address |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_we | input | 1 | Request is a write |
| req_phy | input | 5 | Bus address of the request |
| req_reg | input | 5 | Register number of the request |
| req_wdata | input | 16 | Write value |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response accepted |
| rsp_rdata | output | 16 | Response data |
| rf_en | output | 1 | Register-array access strobe |
| rf_we | output | 1 | Register-array write flag |
| rf_dev | output | 5 | Register-array device |
| rf_reg | output | 5 | Register-array register number |
| rf_wdata | output | 16 | Register-array write value |
| rf_rdata | input | 16 | Read value, valid RF_LATENCY cycles after the strobe |

## Verification
Internal state errors show up at the ports quickly. A stuck or early-clearing busy flag changes the bit-15 value of the next register-0 poll, and it shifts the array strobe relative to the command by at least one cycle. A wrong latency count makes the bridge capture the placeholder value that the bench drives on `rf_rdata` outside the valid cycle, and that value appears in the next register-1 read. Because outputs are compared against the cycle model on every clock, any misrouted field or missing gate on `req_ready` is reported in the cycle it occurs.

// File: rtl/mib_pkg.sv
package mib_pkg;
  localparam int MIB_DATA_W = 16;
  localparam int MIB_ADDR_W = 5;
  localparam int MIB_OP_W   = MIB_DATA_W - 2 * MIB_ADDR_W;

  localparam logic [MIB_OP_W-1:0] MIB_OP_READ  = 6'b100110;
  localparam logic [MIB_OP_W-1:0] MIB_OP_WRITE = 6'b100101;

  localparam logic [MIB_ADDR_W-1:0] MIB_REG_CMD  = 5'd0;
  localparam logic [MIB_ADDR_W-1:0] MIB_REG_DATA = 5'd1;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_ISSUE = 2'd1,
    PH_WAIT  = 2'd2
  } mib_phase_e;
endpackage

// File: rtl/mib_cmd_decode.sv
module mib_cmd_decode
  import mib_pkg::*;
(
  input  logic [MIB_DATA_W-1:0] cmd_word,
  output logic                  cmd_ok,
  output logic                  cmd_write,
  output logic [MIB_ADDR_W-1:0] cmd_dev,
  output logic [MIB_ADDR_W-1:0] cmd_reg
);
  logic [MIB_OP_W-1:0] op;

  always_comb begin
    op        = cmd_word[MIB_DATA_W-1 -: MIB_OP_W];
    cmd_dev   = cmd_word[2*MIB_ADDR_W-1 -: MIB_ADDR_W];
    cmd_reg   = cmd_word[MIB_ADDR_W-1:0];
    cmd_write = (op == MIB_OP_WRITE);
    cmd_ok    = (op == MIB_OP_WRITE) || (op == MIB_OP_READ);
  end
endmodule

// File: rtl/mib_access_engine.sv
module mib_access_engine
  import mib_pkg::*;
#(
  parameter int RF_LATENCY = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic                  start_we,
  input  logic [MIB_ADDR_W-1:0] start_dev,
  input  logic [MIB_ADDR_W-1:0] start_reg,
  input  logic [MIB_DATA_W-1:0] start_wdata,
  output logic                  rf_en,
  output logic                  rf_we,
  output logic [MIB_ADDR_W-1:0] rf_dev,
  output logic [MIB_ADDR_W-1:0] rf_reg,
  output logic [MIB_DATA_W-1:0] rf_wdata,
  output logic                  done,
  output logic                  idle
);
  localparam int CNT_W = $clog2(RF_LATENCY + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RF_LATENCY);

  mib_phase_e             phase_q;
  logic [CNT_W-1:0]       cnt_q;
  logic                   we_q;
  logic [MIB_ADDR_W-1:0]  dev_q;
  logic [MIB_ADDR_W-1:0]  reg_q;
  logic [MIB_DATA_W-1:0]  wd_q;

  assign rf_en    = (phase_q == PH_ISSUE);
  assign rf_we    = we_q;
  assign rf_dev   = dev_q;
  assign rf_reg   = reg_q;
  assign rf_wdata = wd_q;
  assign done     = (phase_q == PH_WAIT) && (cnt_q == CNT_LAST);
  assign idle     = (phase_q == PH_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      we_q    <= 1'b0;
      dev_q   <= '0;
      reg_q   <= '0;
      wd_q    <= '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: begin
          if (start) begin
            phase_q <= PH_ISSUE;
            we_q    <= start_we;
            dev_q   <= start_dev;
            reg_q   <= start_reg;
            wd_q    <= start_wdata;
          end
        end
        PH_ISSUE: begin
          phase_q <= PH_WAIT;
          cnt_q   <= CNT_W'(1);
        end
        PH_WAIT: begin
          if (cnt_q == CNT_LAST) phase_q <= PH_IDLE;
          else                   cnt_q   <= cnt_q + CNT_W'(1);
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mgmt_indirect_bridge.sv
module mgmt_indirect_bridge
  import mib_pkg::*;
#(
  parameter int RF_LATENCY = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [MIB_ADDR_W-1:0] strap_addr,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_we,
  input  logic [MIB_ADDR_W-1:0] req_phy,
  input  logic [MIB_ADDR_W-1:0] req_reg,
  input  logic [MIB_DATA_W-1:0] req_wdata,
  output logic                  rsp_valid,
  input  logic                  rsp_ready,
  output logic [MIB_DATA_W-1:0] rsp_rdata,
  output logic                  rf_en,
  output logic                  rf_we,
  output logic [MIB_ADDR_W-1:0] rf_dev,
  output logic [MIB_ADDR_W-1:0] rf_reg,
  output logic [MIB_DATA_W-1:0] rf_wdata,
  input  logic [MIB_DATA_W-1:0] rf_rdata
);
  localparam logic [MIB_DATA_W-1:0] NO_DEVICE = {MIB_DATA_W{1'b1}};

  logic                  busy_q, dpend_q, rsp_valid_q;
  logic [MIB_DATA_W-1:0] cmd_q, data_q, rsp_data_q;

  logic                  direct, hit, fire, eng_done, eng_idle;
  logic                  cmd_ok, cmd_write, start;
  logic [MIB_ADDR_W-1:0] cmd_dev, cmd_reg;
  logic                  st_we;
  logic [MIB_ADDR_W-1:0] st_dev, st_reg;
  logic [MIB_DATA_W-1:0] st_wd, own_rd;

  assign direct    = (strap_addr == '0);
  assign hit       = (req_phy == strap_addr);
  assign req_ready = !rsp_valid_q && !dpend_q;
  assign fire      = req_valid && req_ready;
  assign rsp_valid = rsp_valid_q;
  assign rsp_rdata = rsp_data_q;

  mib_cmd_decode u_dec (
    .cmd_word (req_wdata),
    .cmd_ok   (cmd_ok),
    .cmd_write(cmd_write),
    .cmd_dev  (cmd_dev),
    .cmd_reg  (cmd_reg)
  );

  always_comb begin
    start = 1'b0;
    if (fire) begin
      if (direct) start = 1'b1;
      else        start = hit && req_we && (req_reg == MIB_REG_CMD) && !busy_q && cmd_ok;
    end
    st_we  = direct ? req_we    : cmd_write;
    st_dev = direct ? req_phy   : cmd_dev;
    st_reg = direct ? req_reg   : cmd_reg;
    st_wd  = direct ? req_wdata : data_q;
  end

  always_comb begin
    unique case (req_reg)
      MIB_REG_CMD:  own_rd = {busy_q, cmd_q[MIB_DATA_W-2:0]};
      MIB_REG_DATA: own_rd = data_q;
      default:      own_rd = '0;
    endcase
  end

  mib_access_engine #(.RF_LATENCY(RF_LATENCY)) u_eng (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .start_we   (st_we),
    .start_dev  (st_dev),
    .start_reg  (st_reg),
    .start_wdata(st_wd),
    .rf_en      (rf_en),
    .rf_we      (rf_we),
    .rf_dev     (rf_dev),
    .rf_reg     (rf_reg),
    .rf_wdata   (rf_wdata),
    .done       (eng_done),
    .idle       (eng_idle)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q      <= 1'b0;
      dpend_q     <= 1'b0;
      rsp_valid_q <= 1'b0;
      cmd_q       <= '0;
      data_q      <= '0;
      rsp_data_q  <= '0;
    end else begin
      if (rsp_valid_q && rsp_ready) rsp_valid_q <= 1'b0;

      if (eng_done) begin
        if (dpend_q) begin
          dpend_q     <= 1'b0;
          rsp_valid_q <= 1'b1;
          rsp_data_q  <= rf_we ? '0 : rf_rdata;
        end else begin
          busy_q <= 1'b0;
          if (!rf_we) data_q <= rf_rdata;
        end
      end

      if (fire) begin
        if (direct) begin
          dpend_q <= 1'b1;
        end else begin
          rsp_valid_q <= 1'b1;
          if (!hit)        rsp_data_q <= req_we ? '0 : NO_DEVICE;
          else if (!req_we) rsp_data_q <= own_rd;
          else begin
            rsp_data_q <= '0;
            if (start) begin
              busy_q <= 1'b1;
              cmd_q  <= req_wdata;
            end else if (req_reg == MIB_REG_DATA && !busy_q) begin
              data_q <= req_wdata;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/mgmt_indirect_bridge_chk.sv
module mgmt_indirect_bridge_chk
  import mib_pkg::*;
(
  input logic                  clk,
  input logic                  rst_n,
  input logic [MIB_ADDR_W-1:0] strap_addr,
  input logic                  req_valid,
  input logic                  req_ready,
  input logic                  req_we,
  input logic [MIB_ADDR_W-1:0] req_phy,
  input logic [MIB_ADDR_W-1:0] req_reg,
  input logic [MIB_DATA_W-1:0] req_wdata,
  input logic                  rsp_valid,
  input logic                  rsp_ready,
  input logic [MIB_DATA_W-1:0] rsp_rdata,
  input logic                  rf_en,
  input logic [MIB_ADDR_W-1:0] rf_dev,
  input logic [MIB_ADDR_W-1:0] rf_reg,
  input logic                  busy
);
  logic fire, own_cmd_wr, op_known;
  assign fire       = req_valid && req_ready;
  assign own_cmd_wr = fire && (strap_addr != '0) && (req_phy == strap_addr)
                      && req_we && (req_reg == MIB_REG_CMD) && !busy;
  assign op_known   = (req_wdata[15:10] == MIB_OP_READ) || (req_wdata[15:10] == MIB_OP_WRITE);

  // R10
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata));

  // R10
  ready_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  // R1
  direct_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire && (strap_addr == '0) |=> rf_en && rf_dev == $past(req_phy) && rf_reg == $past(req_reg));

  // R2
  foreign_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire && (strap_addr != '0) && (req_phy != strap_addr)
    |=> rsp_valid && rsp_rdata == ($past(req_we) ? 16'h0000 : 16'hFFFF));

  // R3
  busy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    own_cmd_wr && op_known |=> busy && rf_en);

  // R9
  bad_opcode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    own_cmd_wr && !op_known |=> !busy && !rf_en);

  // R7
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_en |=> !rf_en);
endmodule

bind mgmt_indirect_bridge mgmt_indirect_bridge_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .strap_addr(strap_addr),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_we    (req_we),
  .req_phy   (req_phy),
  .req_reg   (req_reg),
  .req_wdata (req_wdata),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_rdata (rsp_rdata),
  .rf_en     (rf_en),
  .rf_dev    (rf_dev),
  .rf_reg    (rf_reg),
  .busy      (busy_q)
);

// File: tb/mgmt_indirect_bridge_tb.sv
module mgmt_indirect_bridge_tb;
  localparam int CLK_PERIOD = 10;
  localparam int QTR = CLK_PERIOD / 4;
  localparam int LAT = 4;
  localparam logic [15:0] BADV = 16'h0BAD;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [4:0] strap_addr = 5'd9;
  logic req_valid = 1'b0, req_we = 1'b0, rsp_ready = 1'b1;
  logic [4:0] req_phy = '0, req_reg = '0;
  logic [15:0] req_wdata = '0;
  logic req_ready, rsp_valid, rf_en, rf_we;
  logic [15:0] rsp_rdata, rf_wdata;
  logic [15:0] rf_rdata = BADV;
  logic [4:0] rf_dev, rf_reg;

  int n_checks = 0, n_fail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mgmt_indirect_bridge #(.RF_LATENCY(LAT)) u_dut (
    .clk(clk), .rst_n(rst_n), .strap_addr(strap_addr),
    .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
    .req_phy(req_phy), .req_reg(req_reg), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .rf_en(rf_en), .rf_we(rf_we), .rf_dev(rf_dev), .rf_reg(rf_reg),
    .rf_wdata(rf_wdata), .rf_rdata(rf_rdata)
  );

  function automatic logic [15:0] preload(input int idx);
    return 16'h1000 + 16'(idx * 3);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // register array behind the port, and the cycle reference model
  logic [15:0] mem [0:1023];
  logic [15:0] dly [0:LAT];
  int m_rem;
  logic m_busy, m_we, m_dpend, m_rsp_v;
  logic [4:0] m_dev, m_reg;
  logic [15:0] m_cmd, m_data, m_wd, m_rsp_d;

  always @(negedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 1024; i++) mem[i] = preload(i);
      for (int i = 0; i <= LAT; i++) dly[i] = BADV;
      rf_rdata = BADV;
      m_rem = 0; m_busy = 0; m_we = 0; m_dpend = 0; m_rsp_v = 0;
      m_dev = 0; m_reg = 0; m_cmd = 0; m_data = 0; m_wd = 0; m_rsp_d = 0;
    end else begin
      logic e_ready, e_en, fire, done, old_busy, direct;
      logic [15:0] old_data, rd_now;
      string ftag;
      direct  = (strap_addr == 5'd0);
      ftag    = direct ? "R1" : "R4";
      e_ready = !m_rsp_v && !m_dpend;
      e_en    = (m_rem == LAT + 1);
      chk(req_ready == e_ready, "R10 req_ready", 16'(req_ready), 16'(e_ready));
      chk(rsp_valid == m_rsp_v, "R10 rsp_valid", 16'(rsp_valid), 16'(m_rsp_v));
      if (m_rsp_v) chk(rsp_rdata == m_rsp_d, "R10 rsp_rdata", rsp_rdata, m_rsp_d);
      chk(rf_en == e_en, "R7 rf_en", 16'(rf_en), 16'(e_en));
      if (e_en) begin
        chk(rf_we == m_we, {ftag, " rf_we"}, 16'(rf_we), 16'(m_we));
        chk(rf_dev == m_dev, {ftag, " rf_dev"}, 16'(rf_dev), 16'(m_dev));
        chk(rf_reg == m_reg, {ftag, " rf_reg"}, 16'(rf_reg), 16'(m_reg));
        if (m_we) chk(rf_wdata == m_wd, "R5 rf_wdata", rf_wdata, m_wd);
      end
      // array model
      if (e_en && m_we) mem[32*m_dev + m_reg] = m_wd;
      for (int i = LAT; i > 0; i--) dly[i] = dly[i-1];
      dly[0] = (e_en && !m_we) ? mem[32*m_dev + m_reg] : BADV;
      rd_now = dly[LAT];
      rf_rdata = rd_now;
      // next state
      fire = req_valid && e_ready;
      done = (m_rem == 1);
      old_busy = m_busy;
      old_data = m_data;
      if (m_rsp_v && rsp_ready) m_rsp_v = 0;
      if (m_rem > 0) m_rem--;
      if (done) begin
        if (m_dpend) begin
          m_dpend = 0; m_rsp_v = 1; m_rsp_d = m_we ? 16'h0 : rd_now;
        end else begin
          m_busy = 0;
          if (!m_we) m_data = rd_now;
        end
      end
      if (fire) begin
        if (direct) begin
          m_rem = LAT + 1; m_we = req_we; m_dev = req_phy; m_reg = req_reg;
          m_wd = req_wdata; m_dpend = 1;
        end else if (req_phy != strap_addr) begin
          m_rsp_v = 1; m_rsp_d = req_we ? 16'h0000 : 16'hFFFF;
        end else begin
          m_rsp_v = 1; m_rsp_d = 0;
          if (!req_we) begin
            if (req_reg == 0) m_rsp_d = {old_busy, m_cmd[14:0]};
            else if (req_reg == 1) m_rsp_d = old_data;
          end else if (req_reg == 0 && !old_busy &&
                       (req_wdata[15:10] == 6'b100110 || req_wdata[15:10] == 6'b100101)) begin
            m_busy = 1; m_cmd = req_wdata; m_rem = LAT + 1;
            m_we = (req_wdata[15:10] == 6'b100101);
            m_dev = req_wdata[9:5]; m_reg = req_wdata[4:0]; m_wd = old_data;
          end else if (req_reg == 1 && !old_busy) begin
            m_data = req_wdata;
          end
        end
      end
    end
  end

  task automatic bus_op(input logic we, input logic [4:0] phy, input logic [4:0] rg,
                        input logic [15:0] wd, input int hold, output logic [15:0] rd);
    @(posedge clk); #(QTR);
    req_valid = 1; req_we = we; req_phy = phy; req_reg = rg; req_wdata = wd;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    @(posedge clk); #(QTR);
    req_valid = 0;
    if (hold > 0) rsp_ready = 0;
    @(negedge clk);
    while (!rsp_valid) @(negedge clk);
    rd = rsp_rdata;
    if (hold > 0) begin
      repeat (hold) @(posedge clk);
      #(QTR); rsp_ready = 1;
    end
    @(posedge clk); #(QTR);
  endtask

  task automatic wait_idle(input logic [4:0] own);
    logic [15:0] rd;
    int polls = 0;
    do begin
      bus_op(0, own, 5'd0, 16'h0, 0, rd);
      polls++;
    end while (rd[15] && polls < 40);
    // R7: finishes well within the host's poll budget
    chk(polls <= 16, "R7 poll count", 16'(polls), 16'd16);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 16'h1, 16'h0);
    finish_run();
  end

  initial begin
    logic [15:0] rd;
    repeat (3) @(posedge clk);
    #(QTR); rst_n = 1;
    @(negedge clk);
    // R10 reset state
    chk(req_ready == 1 && rsp_valid == 0 && rf_en == 0, "R10 reset", {rsp_valid, rf_en, 13'h0, req_ready}, 16'h0001);

    // R2 foreign address
    bus_op(0, 5'd3, 5'd0, 16'h0, 0, rd);
    chk(rd == 16'hFFFF, "R2 foreign read", rd, 16'hFFFF);
    bus_op(1, 5'd3, 5'd1, 16'h7777, 0, rd);
    bus_op(0, 5'd9, 5'd1, 16'h0, 0, rd);
    chk(rd == 16'h0000, "R2 foreign write no effect", rd, 16'h0000);

    // R5 write command, R3 busy visible
    bus_op(1, 5'd9, 5'd1, 16'hA5A5, 0, rd);
    bus_op(1, 5'd9, 5'd0, 16'h9400 | (4 << 5) | 7, 0, rd);
    bus_op(0, 5'd9, 5'd0, 16'h0, 0, rd);
    chk(rd == (16'h8000 | (4 << 5) | 7 | 16'h1400), "R3 busy after command", rd, 16'h9487);
    wait_idle(5'd9);
    // R6, R4 read back through a read command
    bus_op(1, 5'd9, 5'd0, 16'h9800 | (4 << 5) | 7, 0, rd);
    wait_idle(5'd9);
    bus_op(0, 5'd9, 5'd1, 16'h0, 0, rd);
    chk(rd == 16'hA5A5, "R6 read result", rd, 16'hA5A5);
    bus_op(1, 5'd9, 5'd0, 16'h9800 | (31 << 5) | 31, 0, rd);
    wait_idle(5'd9);
    bus_op(0, 5'd9, 5'd1, 16'h0, 0, rd);
    chk(rd == preload(1023), "R4 far corner", rd, preload(1023));

    // R8 data write during busy ignored
    bus_op(1, 5'd9, 5'd0, 16'h9800 | (2 << 5) | 3, 0, rd);
    bus_op(1, 5'd9, 5'd1, 16'h1234, 0, rd);
    wait_idle(5'd9);
    bus_op(0, 5'd9, 5'd1, 16'h0, 0, rd);
    chk(rd == preload(67), "R8 data write while busy", rd, preload(67));
    // R8 command write during busy ignored
    bus_op(1, 5'd9, 5'd0, 16'h9800 | (2 << 5) | 4, 0, rd);
    bus_op(1, 5'd9, 5'd0, 16'h9400 | (5 << 5) | 5, 0, rd);
    wait_idle(5'd9);
    bus_op(1, 5'd9, 5'd0, 16'h9800 | (5 << 5) | 5, 0, rd);
    wait_idle(5'd9);
    bus_op(0, 5'd9, 5'd1, 16'h0, 0, rd);
    chk(rd == preload(165), "R8 command while busy", rd, preload(165));

    // R9 unknown opcode
    bus_op(1, 5'd9, 5'd0, 16'hC000 | (6 << 5) | 1, 0, rd);
    bus_op(0, 5'd9, 5'd0, 16'h0, 0, rd);
    chk(rd == 16'h18A5, "R9 unknown opcode", rd, 16'h18A5);

    // R11 unused registers
    bus_op(1, 5'd9, 5'd5, 16'hFFFF, 0, rd);
    bus_op(0, 5'd9, 5'd5, 16'h0, 0, rd);
    chk(rd == 16'h0000, "R11 unused register", rd, 16'h0000);
    bus_op(0, 5'd9, 5'd1, 16'h0, 0, rd);
    chk(rd == preload(165), "R11 write has no effect", rd, preload(165));

    // R10 response back-pressure
    bus_op(0, 5'd9, 5'd1, 16'h0, 4, rd);
    chk(rd == preload(165), "R10 held response", rd, preload(165));

    // R1 direct mode
    @(posedge clk); #(QTR); strap_addr = 5'd0;
    bus_op(1, 5'd7, 5'd2, 16'hBEEF, 0, rd);
    chk(rd == 16'h0000, "R1 direct write response", rd, 16'h0000);
    bus_op(0, 5'd7, 5'd2, 16'h0, 0, rd);
    chk(rd == 16'hBEEF, "R1 direct read back", rd, 16'hBEEF);
    bus_op(0, 5'd0, 5'd0, 16'h0, 3, rd);
    chk(rd == preload(0), "R1 direct address zero", rd, preload(0));
    bus_op(0, 5'd4, 5'd7, 16'h0, 0, rd);
    chk(rd == 16'hA5A5, "R1 direct sees indirect write", rd, 16'hA5A5);

    repeat (4) @(posedge clk);
    finish_run();
  end
endmodule